// File: doc/BRIEF.md
# Store Buffer with Load Bypass

This block sits between one processor's load/store port and a slow memory port. Stores are parked in a small first-in first-out store queue in a single cycle, so the processor can keep issuing work while the queued stores are written to memory one after another. Each memory write holds the port for a fixed, parameterised number of cycles (100 by default). A load whose address is not held in the queue is sent to memory at once, ahead of any older queued stores. A load whose address is held in the queue is stalled until that store has been written to memory. Data is never forwarded from the queue to a load.

The processor side uses a valid/ready handshake with a write/read select, an address and write data. A read answer comes back one cycle after the load is accepted, marked by a response strobe. The memory side has one shared address bus, a one-cycle write strobe, a read strobe and combinational read data.

Top module: `wbuf_bypass`

## Requirements
- R1: While `rst` is high on a clock edge, the queue is emptied and any memory write in progress is dropped. In the cycle after reset, `memWrEn`, `memRdEn` and `rspValid` are all 0, and a store is accepted (`cpuReady` = 1 when `cpuWrite` = 1).
- R2: When the queue has fewer than DEPTH entries, a store (`cpuValid` = 1, `cpuWrite` = 1) is accepted in that cycle. This holds even if queued stores use the same address.
- R3: When the queue holds DEPTH entries, `cpuReady` is 0 for a store. It returns to 1 in the cycle after the oldest entry's write strobe.
- R4: A load (`cpuWrite` = 0) is accepted in the cycle it is offered if two conditions hold: no queued entry has its address, and no memory write is in progress. In that same cycle `memRdEn` = 1 and `memAddr` carries the load address. In the next cycle `rspValid` = 1 and `rspData` holds the memory word read.
- R5: A load is held with `cpuReady` = 0 while any queued entry has its address. This includes the entry currently being written. The earliest it can be accepted is the cycle after that entry's `memWrEn` pulse, and it then returns the stored value.
- R6: Queued stores are written strictly oldest first and one at a time. Each write holds the port for WRITE_LAT cycles. In the last of those cycles `memWrEn` pulses for exactly one cycle, with that entry's address and data on `memAddr` and `memWdata`. Memory sees no other write.
- R7: A write in progress is never interrupted, so a load offered during it stalls even when its address is not queued. When the port is free and a bypassing load is offered, the load is served before the next queued write begins.
- R8: Stores dropped by a reset never cause a `memWrEn` pulse. Their addresses keep the values they held before those stores.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpuValid | input | 1 | Processor request valid |
| cpuWrite | input | 1 | 1 = store, 0 = load |
| cpuAddr | input | ADDR_W | Request address |
| cpuWdata | input | DATA_W | Store data |
| cpuReady | output | 1 | Request accepted in this cycle when high together with cpuValid |
| rspValid | output | 1 | Load answer valid |
| rspData | output | DATA_W | Load answer data |
| memAddr | output | ADDR_W | Memory address (head entry while writing, load address otherwise) |
| memWdata | output | DATA_W | Memory write data |
| memWrEn | output | 1 | One-cycle write commit strobe |
| memRdEn | output | 1 | Memory read strobe |
| memRdData | input | DATA_W | Combinational memory read data |

## Verification
Two events can land in the same cycle. A store can be pushed into the queue in the cycle where the oldest entry's write commits. A load can also become eligible in the cycle where the next write would start. The bench provokes both. It fills the queue so that a stalled store retries while the head drains. It also offers a load right after a store into an empty queue, when the port is idle. A behavioural reference model with a queue and a cycle counter predicts `cpuReady`, both memory strobes, the address and data on the port, and the load answers. The bench compares them on every clock. This judges whether the push and the pop in the same cycle keep the entry count right, and whether the load correctly wins the idle port.

// File: rtl/wbuf_pkg.sv
package wbuf_pkg;
  typedef struct packed {
    logic push;       // store enters the queue
    logic pop;        // head store commits to memory this cycle
    logic readFire;   // load uses the memory port this cycle
    logic drainBusy;  // a memory write is occupying the port
  } wbufStrobes_t;
endpackage

// File: rtl/wbuf_datapath.sv
module wbuf_datapath
  import wbuf_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  wbufStrobes_t      strb,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0] cpuWdata,
  input  logic [DATA_W-1:0] memRdData,
  output logic              full,
  output logic              empty,
  output logic              addrHit,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic              memWrEn,
  output logic              memRdEn,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspData
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST_PTR  = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_CNT  = CNT_W'(DEPTH);

  logic [ADDR_W-1:0] entAddr [DEPTH];
  logic [DATA_W-1:0] entData [DEPTH];
  logic [DEPTH-1:0]  entValid;
  logic [DEPTH-1:0]  hitVec;
  logic [PTR_W-1:0]  wrPtr, rdPtr;
  logic [CNT_W-1:0]  count;

  // address match against every live entry, including the one draining
  for (genvar i = 0; i < DEPTH; i++) begin : g_match
    assign hitVec[i] = entValid[i] && (entAddr[i] == cpuAddr);
  end

  assign addrHit = |hitVec;
  assign full    = (count == FULL_CNT);
  assign empty   = (count == '0);

  always_ff @(posedge clk) begin
    if (strb.push) begin
      entAddr[wrPtr] <= cpuAddr;
      entData[wrPtr] <= cpuWdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      entValid <= '0;
      wrPtr    <= '0;
      rdPtr    <= '0;
      count    <= '0;
    end else begin
      if (strb.pop) begin
        entValid[rdPtr] <= 1'b0;
        rdPtr <= (rdPtr == LAST_PTR) ? '0 : rdPtr + PTR_W'(1);
      end
      if (strb.push) begin
        entValid[wrPtr] <= 1'b1;
        wrPtr <= (wrPtr == LAST_PTR) ? '0 : wrPtr + PTR_W'(1);
      end
      case ({strb.push, strb.pop})
        2'b10:   count <= count + CNT_W'(1);
        2'b01:   count <= count - CNT_W'(1);
        default: count <= count;
      endcase
    end
  end

  assign memAddr  = strb.drainBusy ? entAddr[rdPtr] : cpuAddr;
  assign memWdata = entData[rdPtr];
  assign memWrEn  = strb.pop;
  assign memRdEn  = strb.readFire;

  always_ff @(posedge clk) begin
    if (rst) begin
      rspValid <= 1'b0;
      rspData  <= '0;
    end else begin
      rspValid <= strb.readFire;
      if (strb.readFire) rspData <= memRdData;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    strb.push |-> !full) else $error("push into full queue"); // R3

  AST_POP_HAS_ENTRY: assert property (@(posedge clk) disable iff (rst)
    strb.pop |-> entValid[rdPtr]) else $error("commit of empty slot"); // R6

  AST_READ_NO_HIT: assert property (@(posedge clk) disable iff (rst)
    strb.readFire |-> !addrHit) else $error("load passed a queued store"); // R5
endmodule

// File: rtl/wbuf_ctrl.sv
module wbuf_ctrl
  import wbuf_pkg::*;
#(
  parameter int WRITE_LAT = 100
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cpuValid,
  input  logic         cpuWrite,
  input  logic         full,
  input  logic         empty,
  input  logic         addrHit,
  output logic         cpuReady,
  output wbufStrobes_t strb
);
  localparam int LAT_W = (WRITE_LAT > 1) ? $clog2(WRITE_LAT) : 1;
  localparam logic [LAT_W-1:0] LAST_CNT = LAT_W'(WRITE_LAT - 1);

  typedef enum logic { ST_IDLE, ST_DRAIN } drainState_t;
  drainState_t state;
  logic [LAT_W-1:0] cnt;
  logic busy, lastCycle;

  assign busy      = (state == ST_DRAIN);
  assign lastCycle = busy && (cnt == LAST_CNT);

  always_comb begin
    strb           = '0;
    strb.drainBusy = busy;
    strb.pop       = lastCycle;
    strb.push      = cpuValid && cpuWrite && !full;
    strb.readFire  = cpuValid && !cpuWrite && !busy && !addrHit;
    cpuReady       = cpuWrite ? !full : (!busy && !addrHit);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          cnt <= '0;
          if (!strb.readFire && !empty) state <= ST_DRAIN;
        end
        ST_DRAIN: begin
          if (lastCycle) begin
            state <= ST_IDLE;
            cnt   <= '0;
          end else begin
            cnt <= cnt + LAT_W'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_DRAIN_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (busy && !lastCycle) |=> (busy && cnt == $past(cnt) + LAT_W'(1)))
    else $error("write interrupted"); // R7
endmodule

// File: rtl/wbuf_bypass.sv
module wbuf_bypass
  import wbuf_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 16,
  parameter int DEPTH     = 4,
  parameter int WRITE_LAT = 100
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpuValid,
  input  logic              cpuWrite,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0] cpuWdata,
  output logic              cpuReady,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspData,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic              memWrEn,
  output logic              memRdEn,
  input  logic [DATA_W-1:0] memRdData
);
  wbufStrobes_t strb;
  logic full, empty, addrHit;

  wbuf_ctrl #(.WRITE_LAT(WRITE_LAT)) u_ctrl (
    .clk(clk), .rst(rst), .cpuValid(cpuValid), .cpuWrite(cpuWrite),
    .full(full), .empty(empty), .addrHit(addrHit),
    .cpuReady(cpuReady), .strb(strb)
  );

  wbuf_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) u_dp (
    .clk(clk), .rst(rst), .strb(strb), .cpuAddr(cpuAddr), .cpuWdata(cpuWdata),
    .memRdData(memRdData), .full(full), .empty(empty), .addrHit(addrHit),
    .memAddr(memAddr), .memWdata(memWdata), .memWrEn(memWrEn),
    .memRdEn(memRdEn), .rspValid(rspValid), .rspData(rspData)
  );

  AST_NO_PORT_CLASH: assert property (@(posedge clk) disable iff (rst)
    !(memWrEn && memRdEn)) else $error("read and write share a cycle"); // R7
endmodule

// File: tb/wbuf_bypass_tb.sv
module wbuf_bypass_tb;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 16;
  localparam int DEPTH  = 4;
  localparam int LAT    = 100;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cpuValid = 1'b0, cpuWrite = 1'b0;
  logic [ADDR_W-1:0] cpuAddr = '0;
  logic [DATA_W-1:0] cpuWdata = '0;
  logic cpuReady, rspValid, memWrEn, memRdEn;
  logic [DATA_W-1:0] rspData, memWdata, memRdData;
  logic [ADDR_W-1:0] memAddr;

  always #10 clk = ~clk;  // 50 MHz

  wbuf_bypass #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH), .WRITE_LAT(LAT)) u_dut (
    .clk(clk), .rst(rst), .cpuValid(cpuValid), .cpuWrite(cpuWrite),
    .cpuAddr(cpuAddr), .cpuWdata(cpuWdata), .cpuReady(cpuReady),
    .rspValid(rspValid), .rspData(rspData), .memAddr(memAddr),
    .memWdata(memWdata), .memWrEn(memWrEn), .memRdEn(memRdEn),
    .memRdData(memRdData)
  );

  // memory seen by the block
  logic [DATA_W-1:0] mem [256];
  logic [DATA_W-1:0] refMem [256];
  assign memRdData = mem[memAddr];
  always @(posedge clk) if (memWrEn) mem[memAddr] <= memWdata;

  // reference model state
  typedef struct { logic [ADDR_W-1:0] a; logic [DATA_W-1:0] d; } ent_t;
  ent_t q[$];
  bit   mBusy = 0;
  int   mCnt = 0;
  bit   mRspPend = 0;
  logic [DATA_W-1:0] mRspData = '0;
  bit   abortWindow = 0;

  int checks = 0, errors = 0, cycles = 0;
  bit lastAccept = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int got, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s got %0h exp %0h", tag, what, got, exp);
    end
  endtask

  task automatic step();
    bit full, hit, expReady, expWr, expRd;
    int sizeBefore;
    #1;
    lastAccept = cpuValid && cpuReady;
    if (rst) begin
      q.delete(); mBusy = 0; mCnt = 0; mRspPend = 0;
    end else begin
      full = (q.size() == DEPTH);
      hit = 0;
      foreach (q[i]) if (q[i].a == cpuAddr) hit = 1;
      expReady = cpuWrite ? !full : (!mBusy && !hit);
      expWr = mBusy && (mCnt == LAT - 1);
      expRd = cpuValid && !cpuWrite && !mBusy && !hit;
      if (cpuValid)
        chk(cpuReady == expReady,
            cpuWrite ? (full ? "R3" : "R2") : (hit ? "R5" : (mBusy ? "R7" : "R4")),
            "cpuReady", cpuReady, expReady);
      chk(memWrEn == expWr, abortWindow ? "R8" : "R6", "memWrEn", memWrEn, expWr);
      if (expWr) begin
        chk(memAddr == q[0].a, "R6", "memAddr(wr)", memAddr, q[0].a);
        chk(memWdata == q[0].d, "R6", "memWdata", memWdata, q[0].d);
      end
      chk(memRdEn == expRd, "R4", "memRdEn", memRdEn, expRd);
      if (expRd) chk(memAddr == cpuAddr, "R4", "memAddr(rd)", memAddr, cpuAddr);
      chk(rspValid == mRspPend, "R4", "rspValid", rspValid, mRspPend);
      if (mRspPend) chk(rspData == mRspData, "R5", "rspData", rspData, mRspData);
      // advance model
      sizeBefore = q.size();
      mRspPend = expRd;
      if (expRd) mRspData = refMem[cpuAddr];
      if (expWr) begin
        refMem[q[0].a] = q[0].d;
        void'(q.pop_front());
        mBusy = 0; mCnt = 0;
      end else if (mBusy) begin
        mCnt++;
      end else if (!expRd && sizeBefore > 0) begin
        mBusy = 1; mCnt = 0;
      end
      if (cpuValid && cpuWrite && !full) q.push_back('{cpuAddr, cpuWdata});
    end
    @(posedge clk);
    #2;
  endtask

  task automatic idle(input int n);
    cpuValid = 0;
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic doOp(input bit w, input logic [ADDR_W-1:0] a,
                      input logic [DATA_W-1:0] d);
    cpuValid = 1; cpuWrite = w; cpuAddr = a; cpuWdata = d;
    for (int i = 0; i < 2000; i++) begin
      step();
      if (lastAccept) break;
    end
    cpuValid = 0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) begin
      mem[i] = DATA_W'(i * 3 + 1);
      refMem[i] = DATA_W'(i * 3 + 1);
    end
    @(posedge clk); #2;
    rst = 1; idle(3);
    rst = 0;
    // R1: quiet after reset, store accepted
    #1;
    chk(memWrEn == 0 && memRdEn == 0 && rspValid == 0, "R1", "strobes", 0, 0);
    cpuValid = 1; cpuWrite = 1; cpuAddr = 8'h10; cpuWdata = 16'h1111;
    #1;
    chk(cpuReady == 1, "R1", "cpuReady", cpuReady, 1);
    @(posedge clk); #2;
    // the store was taken at that edge; keep the model in step by replaying it
    q.push_back('{8'h10, 16'h1111});
    cpuValid = 0;
    // R4/R7: bypass load wins the idle port over starting the write
    doOp(0, 8'h20, '0);
    // R5: load hitting the queued store waits for its commit
    doOp(0, 8'h10, '0);
    idle(2);
    // R2: same-address stores, R3: full queue
    doOp(1, 8'h30, 16'hA001);
    doOp(1, 8'h30, 16'hA002);
    doOp(1, 8'h31, 16'hA003);
    doOp(1, 8'h32, 16'hA004);
    doOp(1, 8'h33, 16'hA005);
    // R7: non-hitting load stalls behind a write in progress
    doOp(0, 8'h40, '0);
    // R5: latest same-address value after both drains
    doOp(0, 8'h30, '0);
    idle(600);
    doOp(0, 8'h33, '0);
    // R8: reset in the middle of a write
    doOp(1, 8'h50, 16'hBEEF);
    doOp(1, 8'h51, 16'hCAFE);
    idle(40);
    rst = 1; idle(2); rst = 0;
    abortWindow = 1;
    idle(250);
    abortWindow = 0;
    doOp(0, 8'h50, '0);
    doOp(0, 8'h51, '0);
    idle(3);
    chk(mem[8'h50] == DATA_W'(8'h50 * 3 + 1), "R8", "mem[50]", mem[8'h50], 8'h50 * 3 + 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule